// File: doc/BRIEF.md
# One-Pulse-Per-Second Phase Measurement Counter

This block measures the phase of a disciplined 10 MHz oscillator against a satellite-derived one-pulse-per-second (PPS) input, as the front end of a disciplined-oscillator control loop. The oscillator is divided down to a slow reference square wave. A phase window opens on each PPS rising edge and closes on the next rising edge of the divided reference. A free-running counting clock, unrelated to both inputs, measures how long the window stays open. In a locked system the count per second hovers around 1024, and the loop steers by seeing it wander slightly above and below that value.

The PPS input, the oscillator and the counting clock are mutually asynchronous. The divided reference is produced as a registered level in the oscillator domain. The PPS and the reference then each pass through a multi-flop synchronizer into the counting domain. The window is opened, closed and counted only from these synchronized levels, so a metastable sample can never reach the counter bits. Each accepted per-window count is added into an accumulator. After a fixed number of accepted samples the sum is presented with a one-cycle valid strobe to the downstream loop, and the accumulator restarts from zero. A window that stays open past the count limit, as happens when reference edges go missing, raises a saturation flag and is kept out of the sum.

Top module: `pps_phase_meter`

## Requirements
- R1: A synchronous active-high reset on `rst` clears the window, the counters and the accumulator. In the cycle after a reset edge, `sum_valid_o`, `sat_o`, `meas_o` and `sum_o` are all zero.
- R2: The oscillator is divided by 32. The reference is high during the upper half of each 32-cycle phase, and the phase counter restarts from zero through a two-flop reset synchronizer in the oscillator domain. With the oscillator stopped across reset release, the first reference rise comes on the 18th oscillator rising edge after restart, and every 32 edges after that.
- R3: PPS and reference each cross through a two-flop synchronizer followed by rising-edge detection. The window count therefore equals the number of counting-clock edges from the edge that first samples PPS high to the edge that first samples the reference high.
- R4: A PPS rise while the window is already open has no effect on that window. A reference rise while the window is closed has no effect. When both rises are detected in the same cycle with the window closed, the window opens.
- R5: `meas_o` takes the finished window count on the closing edge, which is two counting-clock edges after the reference is first sampled high. It holds that value until the next close.
- R6: The window count stops at 4096. `sat_o` rises once the count exceeds 4095, and stays high until the next window opens.
- R7: A saturated window is excluded from the accumulator and does not advance the sample count.
- R8: On the closing edge of the 30th accepted window, `sum_valid_o` goes high for exactly one cycle with `sum_o` equal to the 32-bit sum of those 30 counts. The accumulator then starts again from zero.
- R9: `sum_o` holds its value between valid strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cnt | input | 1 | Free-running counting clock; all outputs are in this domain |
| rst | input | 1 | Synchronous active-high reset, counting domain |
| osc_clk | input | 1 | Disciplined oscillator clock to be divided |
| pps_in | input | 1 | Asynchronous one-pulse-per-second input |
| meas_o | output | 13 | Last finished window count (capped at 4096) |
| sat_o | output | 1 | Window count exceeded the limit since the window opened |
| sum_o | output | 32 | Sum of the last block of accepted counts |
| sum_valid_o | output | 1 | One-cycle strobe marking a new `sum_o` |

## Verification
PPS pulses arrive at random gaps against a slow free-running reference. This yields window counts spread across the whole reference period, which exposes any off-by-one in the synchronizer latency or the count, and it confirms that reference edges outside a window are ignored. A directed second PPS pulse shortly after the first separates a design that restarts an open window from one that ignores the extra pulse. A long oscillator stall holds one window open past the limit, which checks the cap, the flag and its clearing, and the exclusion of that window from the block sum. Running three full blocks checks the strobe timing, the accumulator restart and the holding of `sum_o` between strobes.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_OPEN = 1'b1
  } win_state_e;

  // Number of bits needed to represent the value v.
  function automatic int unsigned bits_for(input int unsigned v);
    return $clog2(v + 1);
  endfunction

endpackage

// File: rtl/pmc_sync.sv
module pmc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pmc_refdiv.sv
module pmc_refdiv #(
  parameter int RATIO  = 32,
  parameter int STAGES = 2
) (
  input  logic osc_clk,
  input  logic rst,
  output logic ref_o
);

  localparam int DW   = $clog2(RATIO);
  localparam int HALF = RATIO / 2;
  localparam bit POW2 = ((1 << DW) == RATIO);

  logic          rst_osc;
  logic [DW-1:0] phase_q;
  logic [DW-1:0] phase_nxt;
  logic          ref_nxt;
  logic          ref_q;

  // reset crosses into the oscillator domain before it is used
  pmc_sync #(.STAGES(STAGES)) u_rst_sync (
    .clk (osc_clk),
    .rst (1'b0),
    .d   (rst),
    .q   (rst_osc)
  );

  function automatic logic [DW-1:0] wrap_inc(input logic [DW-1:0] p);
    if (p == DW'(RATIO - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign phase_nxt = wrap_inc(phase_q);

  generate
    if (POW2) begin : g_msb
      assign ref_nxt = phase_nxt[DW-1];
    end else begin : g_cmp
      assign ref_nxt = (phase_nxt >= DW'(HALF));
    end
  endgenerate

  always_ff @(posedge osc_clk) begin
    if (rst_osc) begin
      phase_q <= '0;
      ref_q   <= 1'b0;
    end else begin
      phase_q <= phase_nxt;
      ref_q   <= ref_nxt;
    end
  end

  assign ref_o = ref_q;

endmodule

// File: rtl/pmc_window.sv
module pmc_window
  import pmc_pkg::*;
#(
  parameter int CNT_W     = 13,
  parameter int SAT_LIMIT = 4095
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pps_lvl,
  input  logic             ref_lvl,
  output logic             pps_rise,
  output logic             ref_rise,
  output logic             win_open,
  output logic             close_evt,
  output logic             close_sat,
  output logic [CNT_W-1:0] close_val,
  output logic [CNT_W-1:0] win_cnt,
  output logic [CNT_W-1:0] meas_o,
  output logic             sat_o
);

  win_state_e       state_q;
  logic             pps_prev;
  logic             ref_prev;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] meas_q;
  logic             sat_q;

  // saturating increment: stops one above the limit
  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] c);
    if (c > CNT_W'(SAT_LIMIT)) return c;
    return c + 1'b1;
  endfunction

  function automatic logic over_limit(input logic [CNT_W-1:0] c);
    return c > CNT_W'(SAT_LIMIT);
  endfunction

  assign pps_rise  = pps_lvl & ~pps_prev;
  assign ref_rise  = ref_lvl & ~ref_prev;
  assign win_open  = (state_q == WIN_OPEN);
  assign cnt_nxt   = count_step(cnt_q);
  assign close_evt = win_open & ref_rise;
  assign close_val = cnt_nxt;
  assign close_sat = over_limit(cnt_nxt);

  always_ff @(posedge clk) begin
    if (rst) begin
      pps_prev <= 1'b0;
      ref_prev <= 1'b0;
    end else begin
      pps_prev <= pps_lvl;
      ref_prev <= ref_lvl;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WIN_IDLE;
      cnt_q   <= '0;
      meas_q  <= '0;
      sat_q   <= 1'b0;
    end else begin
      case (state_q)
        WIN_IDLE: begin
          if (pps_rise) begin
            state_q <= WIN_OPEN;
            cnt_q   <= '0;
            sat_q   <= 1'b0;
          end
        end
        WIN_OPEN: begin
          cnt_q <= cnt_nxt;
          sat_q <= sat_q | over_limit(cnt_nxt);
          if (ref_rise) begin
            state_q <= WIN_IDLE;
            meas_q  <= cnt_nxt;
          end
        end
        default: state_q <= WIN_IDLE;
      endcase
    end
  end

  assign win_cnt = cnt_q;
  assign meas_o  = meas_q;
  assign sat_o   = sat_q;

endmodule

// File: rtl/pmc_accum.sv
module pmc_accum #(
  parameter int CNT_W   = 13,
  parameter int ACC_W   = 32,
  parameter int SAMPLES = 30,
  parameter int IDX_W   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             close_evt,
  input  logic             close_sat,
  input  logic [CNT_W-1:0] close_val,
  output logic [ACC_W-1:0] sum_o,
  output logic             sum_valid_o,
  output logic [IDX_W-1:0] sample_idx
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum_q;
  logic [IDX_W-1:0] idx_q;
  logic             valid_q;
  logic             accept;
  logic             last;

  function automatic logic [ACC_W-1:0] fold(input logic [ACC_W-1:0] a,
                                            input logic [CNT_W-1:0] v);
    return a + ACC_W'(v);
  endfunction

  assign accept = close_evt & ~close_sat;
  assign last   = (idx_q == IDX_W'(SAMPLES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      sum_q   <= '0;
      idx_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (accept) begin
        if (last) begin
          sum_q   <= fold(acc_q, close_val);
          valid_q <= 1'b1;
          acc_q   <= '0;
          idx_q   <= '0;
        end else begin
          acc_q <= fold(acc_q, close_val);
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  assign sum_o       = sum_q;
  assign sum_valid_o = valid_q;
  assign sample_idx  = idx_q;

endmodule

// File: rtl/pps_phase_meter.sv
module pps_phase_meter
  import pmc_pkg::*;
#(
  parameter int DIV_RATIO   = 32,
  parameter int SYNC_STAGES = 2,
  parameter int SAMPLES     = 30,
  parameter int SAT_LIMIT   = 4095,
  parameter int ACC_W       = 32,
  localparam int CNT_W      = bits_for(SAT_LIMIT + 1),
  localparam int IDX_W      = (SAMPLES > 1) ? $clog2(SAMPLES) : 1
) (
  input  logic             clk_cnt,
  input  logic             rst,
  input  logic             osc_clk,
  input  logic             pps_in,
  output logic [CNT_W-1:0] meas_o,
  output logic             sat_o,
  output logic [ACC_W-1:0] sum_o,
  output logic             sum_valid_o
);

  logic             ref_osc;
  logic             pps_lvl;
  logic             ref_lvl;
  logic             pps_rise;
  logic             ref_rise;
  logic             win_open;
  logic             close_evt;
  logic             close_sat;
  logic [CNT_W-1:0] close_val;
  logic [CNT_W-1:0] win_cnt;
  logic [IDX_W-1:0] sample_idx;

  pmc_refdiv #(.RATIO(DIV_RATIO), .STAGES(SYNC_STAGES)) u_div (
    .osc_clk (osc_clk),
    .rst     (rst),
    .ref_o   (ref_osc)
  );

  pmc_sync #(.STAGES(SYNC_STAGES)) u_pps_sync (
    .clk (clk_cnt),
    .rst (rst),
    .d   (pps_in),
    .q   (pps_lvl)
  );

  pmc_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
    .clk (clk_cnt),
    .rst (rst),
    .d   (ref_osc),
    .q   (ref_lvl)
  );

  pmc_window #(.CNT_W(CNT_W), .SAT_LIMIT(SAT_LIMIT)) u_win (
    .clk       (clk_cnt),
    .rst       (rst),
    .pps_lvl   (pps_lvl),
    .ref_lvl   (ref_lvl),
    .pps_rise  (pps_rise),
    .ref_rise  (ref_rise),
    .win_open  (win_open),
    .close_evt (close_evt),
    .close_sat (close_sat),
    .close_val (close_val),
    .win_cnt   (win_cnt),
    .meas_o    (meas_o),
    .sat_o     (sat_o)
  );

  pmc_accum #(.CNT_W(CNT_W), .ACC_W(ACC_W), .SAMPLES(SAMPLES), .IDX_W(IDX_W)) u_acc (
    .clk         (clk_cnt),
    .rst         (rst),
    .close_evt   (close_evt),
    .close_sat   (close_sat),
    .close_val   (close_val),
    .sum_o       (sum_o),
    .sum_valid_o (sum_valid_o),
    .sample_idx  (sample_idx)
  );

endmodule

// File: rtl/pps_phase_meter_chk.sv
module pps_phase_meter_chk #(
  parameter int SAMPLES   = 30,
  parameter int SAT_LIMIT = 4095,
  parameter int CNT_W     = 13,
  parameter int IDX_W     = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             pps_rise,
  input logic             ref_rise,
  input logic             win_open,
  input logic             close_evt,
  input logic [CNT_W-1:0] win_cnt,
  input logic [CNT_W-1:0] meas,
  input logic [IDX_W-1:0] sample_idx,
  input logic             sum_valid,
  input logic             sat
);

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!sum_valid && !sat && meas == '0));

  assert_open_on_pps_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(win_open) |-> $past(pps_rise));

  assert_close_on_ref_R4: assert property (@(posedge clk) disable iff (rst)
    $fell(win_open) |-> ($past(ref_rise) || $past(rst)));

  assert_meas_on_close_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(meas) |-> ($past(close_evt) || $past(rst)));

  assert_count_cap_R6: assert property (@(posedge clk) disable iff (rst)
    int'(win_cnt) <= SAT_LIMIT + 1);

  assert_sat_in_window_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sat) |-> $past(win_open));

  assert_single_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    sum_valid |=> !sum_valid);

  assert_idx_range_R8: assert property (@(posedge clk) disable iff (rst)
    int'(sample_idx) < SAMPLES);

endmodule

bind pps_phase_meter pps_phase_meter_chk #(
  .SAMPLES   (SAMPLES),
  .SAT_LIMIT (SAT_LIMIT),
  .CNT_W     (CNT_W),
  .IDX_W     (IDX_W)
) u_chk (
  .clk        (clk_cnt),
  .rst        (rst),
  .pps_rise   (pps_rise),
  .ref_rise   (ref_rise),
  .win_open   (win_open),
  .close_evt  (close_evt),
  .win_cnt    (win_cnt),
  .meas       (meas_o),
  .sample_idx (sample_idx),
  .sum_valid  (sum_valid_o),
  .sat        (sat_o)
);

// File: tb/pps_phase_meter_tb.sv
module pps_phase_meter_tb;

  localparam int DIV     = 32;
  localparam int FIRST_K = 18;
  localparam int NSAMP   = 30;
  localparam int CAP     = 4096;

  logic        clk_cnt = 1'b0;
  logic        rst     = 1'b1;
  logic        osc_clk = 1'b0;
  logic        pps_in  = 1'b0;
  logic [12:0] meas_o;
  logic        sat_o;
  logic [31:0] sum_o;
  logic        sum_valid_o;

  pps_phase_meter u_dut (
    .clk_cnt     (clk_cnt),
    .rst         (rst),
    .osc_clk     (osc_clk),
    .pps_in      (pps_in),
    .meas_o      (meas_o),
    .sat_o       (sat_o),
    .sum_o       (sum_o),
    .sum_valid_o (sum_valid_o)
  );

  always #4 clk_cnt = ~clk_cnt;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  always @(posedge clk_cnt) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  // ---------------- oscillator and reference model ----------------
  bit osc_run  = 1'b0;
  bit model_on = 1'b0;
  int k        = 0;
  int ref_ev   = -1;
  int pps_ev   = -1;

  function automatic bit is_ref_edge(input int kk);
    return (kk >= FIRST_K) && (((kk - FIRST_K) % DIV) == 0);
  endfunction

  always @(negedge clk_cnt) begin
    if (osc_run) begin
      if (!osc_clk && model_on) begin
        k++;
        if (is_ref_edge(k)) ref_ev = cyc + 1;
      end
      osc_clk <= ~osc_clk;
    end
  end

  // ---------------- window and accumulator model ----------------
  bit          open_w    = 1'b0;
  int          open_edge = 0;
  int          meas_edge = -1;
  int          exp_meas  = 0;
  bit          exp_sat   = 1'b0;
  string       meas_tag  = "R3";
  bit          first_win = 1'b1;
  bit          dbl_mark  = 1'b0;
  bit          win_dbl   = 1'b0;
  bit          blk_sat   = 1'b0;
  longint      acc       = 0;
  int          nacc      = 0;
  int          blocks    = 0;
  longint      sum_q[$];
  int          edge_q[$];
  bit          tag_q[$];
  longint      last_sum  = 0;

  always @(posedge clk_cnt) begin
    int e;
    int n;
    e = cyc + 1;
    if (model_on) begin
      if (!open_w) begin
        if (pps_ev == e) begin
          open_w    = 1'b1;
          open_edge = e;
          win_dbl   = dbl_mark;
        end
      end else if (ref_ev == e) begin
        n         = e - open_edge;
        open_w    = 1'b0;
        meas_edge = e + 2;
        exp_meas  = (n > CAP) ? CAP : n;
        exp_sat   = (n >= CAP);
        meas_tag  = first_win ? "R2" : (win_dbl ? "R4" : (exp_sat ? "R6" : "R3"));
        first_win = 1'b0;
        if (exp_sat) begin
          blk_sat = 1'b1;
        end else begin
          acc += n;
          nacc++;
          if (nacc == NSAMP) begin
            sum_q.push_back(acc);
            edge_q.push_back(e + 2);
            tag_q.push_back(blk_sat);
            acc     = 0;
            nacc    = 0;
            blk_sat = 1'b0;
            blocks++;
          end
        end
      end
    end
  end

  // ---------------- output monitor ----------------
  always @(negedge clk_cnt) begin
    if (model_on) begin
      if (meas_edge == cyc) begin
        chk(meas_o == 13'(exp_meas), {meas_tag, " R5 window count"}, meas_o, exp_meas);
        chk(sat_o == exp_sat, "R6 saturation flag", sat_o, exp_sat);
        if (!sum_valid_o) chk(sum_o == 32'(last_sum), "R9 sum holds", sum_o, last_sum);
      end
      if (sum_valid_o) begin
        if (edge_q.size() == 0 || edge_q[0] != cyc) begin
          chk(1'b0, "R8 unexpected strobe", cyc, (edge_q.size() == 0) ? -1 : edge_q[0]);
        end else begin
          chk(sum_o == 32'(sum_q[0]), tag_q[0] ? "R7 sum without saturated window" : "R8 block sum",
              sum_o, sum_q[0]);
          last_sum = sum_q[0];
          void'(sum_q.pop_front());
          void'(edge_q.pop_front());
          void'(tag_q.pop_front());
        end
      end else if (edge_q.size() != 0 && edge_q[0] == cyc) begin
        chk(1'b0, "R8 missing strobe", 0, 1);
        last_sum = sum_q[0];
        void'(sum_q.pop_front());
        void'(edge_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic pulse_pps();
    @(negedge clk_cnt);
    pps_in = 1'b1;
    pps_ev = cyc + 1;
    repeat (3) @(negedge clk_cnt);
    pps_in = 1'b0;
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_cnt);
    chk(1'b0, "watchdog", cyc, 0);
    finish_test();
  end

  initial begin
    int gap;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk_cnt);
    osc_run = 1'b1;
    repeat (20) @(negedge clk_cnt);
    chk(sum_valid_o == 1'b0, "R1 strobe low in reset", sum_valid_o, 0);
    chk(sat_o == 1'b0, "R1 flag low in reset", sat_o, 0);
    chk(meas_o == 13'd0, "R1 count zero in reset", meas_o, 0);
    chk(sum_o == 32'd0, "R1 sum zero in reset", sum_o, 0);
    osc_run = 1'b0;
    @(negedge clk_cnt);
    rst = 1'b0;
    repeat (10) @(negedge clk_cnt);
    chk(sum_o == 32'd0 && meas_o == 13'd0, "R1 idle after release", sum_o, 0);
    model_on = 1'b1;
    osc_run  = 1'b1;

    for (int i = 0; i < 400 && blocks < 3; i++) begin
      gap = 70 + int'($urandom % 230);
      repeat (gap) @(negedge clk_cnt);
      dbl_mark = (i == 10);
      pulse_pps();
      dbl_mark = 1'b0;
      if (i == 10) begin
        // second pulse while the window is normally still open: R4
        repeat (2) @(negedge clk_cnt);
        pulse_pps();
      end
      if (i == 45) begin
        // stall the oscillator so the window overruns the limit: R6, R7
        repeat (4) @(negedge clk_cnt);
        osc_run = 1'b0;
        repeat (4300) @(negedge clk_cnt);
        chk(sat_o == 1'b1, "R6 flag during overrun", sat_o, 1);
        osc_run = 1'b1;
      end
    end

    repeat (300) @(negedge clk_cnt);
    chk(blocks == 3, "R8 three blocks produced", blocks, 3);
    chk(edge_q.size() == 0, "R8 all strobes seen", edge_q.size(), 0);
    finish_test();
  end

endmodule